// File: doc/BRIEF.md
# ROM Segment CRC Self-Check Engine

This block proves the integrity of read-only program storage at power-on. The storage is split into fixed segments of 3072 16-bit words (6 KiB). Each segment is read in ascending word order and every word, including a trailer word and a final filler word, is folded into a 16-bit CRC. The CRC starts at 0xFFFF. The filler is chosen when the image is built so that an intact segment leaves the CRC register at exactly 0x0000. The second-to-last word of a segment is a trailer: its high byte is a flag and its low byte is the segment number. Both are reported with the pass or fail result of the segment.

A sequencer works through a list of up to 16 segment numbers supplied on the `seg_list` pins. Entry 0 sits in bits [7:0], entry 1 in bits [15:8], and so on. It checks the segments in list order, so a start-up order such as 0x18 first and then 0x10 through 0x17 is just a list. The low nibble of a segment number selects its slot, and the slot's first word address is `nibble * 3072`. The sequencer stops at the first failing segment. It latches that segment's list number and its final CRC residue, and raises `error`. If every listed segment passes, it pulses `done`.

Reads go out on a valid/ready request channel that carries a word address. Data comes back on a response channel that must preserve request order. The engine may have any number of requests outstanding. It asserts `rsp_ready` for as long as a segment is being read and accepts every response that arrives in that time, so the memory side needs no flow control on returns. The memory may stall requests by holding `req_ready` low for any number of cycles.

Top module: `rom_selftest`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `req_valid` and `seg_valid` are all low.
- R2: For a segment number N, the engine requests word addresses `N[3:0]*3072` up to `N[3:0]*3072+3071`, each exactly once and in ascending order.
- R3: The CRC of a segment starts at 0xFFFF. Each word is taken MSB first with polynomial 0x1021 and no final inversion. The segment passes only if the register holds 0x0000 after its last word.
- R4: With each result, `seg_flag` carries the high byte and `seg_id` the low byte of the word at offset 3070 in the segment.
- R5: `seg_valid` is high for exactly one cycle, in the cycle after the clock edge that accepted the segment's last response.
- R6: Segments are checked in list order, from entry 0 to entry `seg_count-1`.
- R7: On a failing segment, `error` rises one cycle after `seg_valid`. At that point `fail_seg` holds the list entry and `fail_residue` holds the final CRC. No further requests are issued, and these outputs hold until the next accepted start.
- R8: `done` pulses for one cycle, one cycle after the `seg_valid` of the last listed segment, if that segment passed.
- R9: `start` is ignored while `busy` is high. An accepted start clears `error`.
- R10: A start with `seg_count` of 0 pulses `done` one cycle later and issues no requests.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_addr` hold. Responses may arrive with any gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check of the list (taken only when idle) |
| seg_count | input | 5 | Number of valid list entries, 0 to 16 |
| seg_list | input | 128 | Segment numbers, entry k in bits [8k+7:8k]; held stable while busy |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 16 | Word address of the request |
| rsp_valid | input | 1 | Read data valid, in request order |
| rsp_ready | output | 1 | High while a segment is being read |
| rsp_data | input | 16 | Read data word |
| seg_valid | output | 1 | One-cycle per-segment result strobe |
| seg_pass | output | 1 | Segment residue was zero |
| seg_flag | output | 8 | Trailer flag byte |
| seg_id | output | 8 | Trailer segment number |
| busy | output | 1 | A list check is in progress |
| done | output | 1 | One-cycle pulse: whole list passed |
| error | output | 1 | A segment failed; held until next start |
| fail_seg | output | 8 | List number of the failing segment |
| fail_residue | output | 16 | Final CRC of the failing segment |

## Verification
Each request address is due on the handshake edge and is checked against a queue of expected addresses at the falling edge before that handshake. A segment's result shows up one cycle after its last response is accepted, so the model compares `seg_valid` in the falling edge that follows that response. `done` and `error` arrive one further cycle later, as does the clearing of `error` after a start or a `done` for an empty list. The model holds each of these as a pending value for exactly one falling edge before comparing it. A start given while busy must leave the address stream unchanged; any restart would show up as an address mismatch.

// File: rtl/romchk_pkg.sv
package romchk_pkg;

  typedef struct packed {
    logic        pass;
    logic [7:0]  flag;
    logic [7:0]  id;
  } seg_result_t;

  // One 16-bit word folded into the CRC, most significant bit first.
  function automatic logic [15:0] crc_fold(input logic [15:0] c,
                                           input logic [15:0] w,
                                           input logic [15:0] poly);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      fb = r[15] ^ w[i];
      r  = {r[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
    end
    return r;
  endfunction

endpackage

// File: rtl/romchk_crc.sv
module romchk_crc #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [15:0] data,
  output logic [15:0] crc_next
);
  logic [15:0] crc_q;

  assign crc_next = romchk_pkg::crc_fold(crc_q, data, POLY);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= SEED;
    else if (init) crc_q <= SEED;
    else if (en)   crc_q <= crc_next;
  end
endmodule

// File: rtl/romchk_reader.sv
module romchk_reader #(
  parameter int          SEG_WORDS = 3072,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] POLY      = 16'h1021,
  localparam int         OFF_W     = $clog2(SEG_WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic [ADDR_W-1:0]       base,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [ADDR_W-1:0]       req_addr,
  input  logic                    rsp_valid,
  output logic                    rsp_ready,
  input  logic [15:0]             rsp_data,
  output logic                    res_valid,
  output romchk_pkg::seg_result_t res,
  output logic [15:0]             res_residue
);
  localparam logic [OFF_W-1:0] TRAIL_OFF = OFF_W'(SEG_WORDS - 2);
  localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(SEG_WORDS - 1);
  localparam logic [OFF_W-1:0] END_OFF   = OFF_W'(SEG_WORDS);

  logic              busy_q;
  logic [OFF_W-1:0]  iss_q, rcv_q;
  logic [ADDR_W-1:0] base_q;
  logic [7:0]        flag_q, id_q;
  logic [15:0]       crc_next;
  logic              take;

  assign req_valid = busy_q && (iss_q != END_OFF);
  assign req_addr  = base_q + ADDR_W'(iss_q);
  assign rsp_ready = busy_q;
  assign take      = busy_q && rsp_valid;

  romchk_crc #(.POLY(POLY), .SEED(16'hFFFF)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(go), .en(take),
    .data(rsp_data), .crc_next(crc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      iss_q       <= '0;
      rcv_q       <= '0;
      base_q      <= '0;
      flag_q      <= '0;
      id_q        <= '0;
      res_valid   <= 1'b0;
      res         <= '0;
      res_residue <= '0;
    end else begin
      res_valid <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
        iss_q  <= '0;
        rcv_q  <= '0;
        base_q <= base;
      end else begin
        if (req_valid && req_ready) iss_q <= iss_q + 1'b1;
        if (take) begin
          rcv_q <= rcv_q + 1'b1;
          if (rcv_q == TRAIL_OFF) {flag_q, id_q} <= rsp_data;
          if (rcv_q == LAST_OFF) begin
            busy_q      <= 1'b0;
            res_valid   <= 1'b1;
            res.pass    <= (crc_next == 16'h0000);
            res.flag    <= flag_q;
            res.id      <= id_q;
            res_residue <= crc_next;
          end
        end
      end
    end
  end
endmodule

// File: rtl/romchk_seq.sv
module romchk_seq #(
  parameter int  SEG_WORDS = 3072,
  parameter int  MAX_SEGS  = 16,
  parameter int  ADDR_W    = 16,
  localparam int CNT_W     = $clog2(MAX_SEGS + 1),
  localparam int IDX_W     = (MAX_SEGS > 1) ? $clog2(MAX_SEGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      seg_count,
  input  logic [MAX_SEGS*8-1:0] seg_list,
  input  logic                  res_valid,
  input  logic                  res_pass,
  input  logic [15:0]           res_residue,
  output logic                  go,
  output logic [ADDR_W-1:0]     base,
  output logic                  busy,
  output logic                  done,
  output logic                  error,
  output logic [7:0]            fail_seg,
  output logic [15:0]           fail_residue
);
  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t           state_q;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic [7:0]       ids [MAX_SEGS];
  logic             last;

  for (genvar g = 0; g < MAX_SEGS; g++) begin : g_ids
    assign ids[g] = seg_list[g*8 +: 8];
  end

  function automatic logic [ADDR_W-1:0] slot_base(input logic [7:0] id);
    return ADDR_W'(id[3:0]) * ADDR_W'(SEG_WORDS);
  endfunction

  assign busy    = (state_q == S_RUN);
  assign idx_nxt = idx_q + 1'b1;
  assign last    = (CNT_W'(idx_q) + CNT_W'(1)) == seg_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      idx_q        <= '0;
      go           <= 1'b0;
      base         <= '0;
      done         <= 1'b0;
      error        <= 1'b0;
      fail_seg     <= '0;
      fail_residue <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          error <= 1'b0;
          idx_q <= '0;
          if (seg_count == '0) begin
            done <= 1'b1;
          end else begin
            state_q <= S_RUN;
            go      <= 1'b1;
            base    <= slot_base(ids[0]);
          end
        end
        S_RUN: if (res_valid) begin
          if (!res_pass) begin
            error        <= 1'b1;
            fail_seg     <= ids[idx_q];
            fail_residue <= res_residue;
            state_q      <= S_IDLE;
          end else if (last) begin
            done    <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            idx_q <= idx_nxt;
            go    <= 1'b1;
            base  <= slot_base(ids[idx_nxt]);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rom_selftest.sv
module rom_selftest #(
  parameter int          SEG_WORDS = 3072,
  parameter int          MAX_SEGS  = 16,
  parameter logic [15:0] POLY      = 16'h1021,
  localparam int         ADDR_W    = $clog2(SEG_WORDS * 16),
  localparam int         CNT_W     = $clog2(MAX_SEGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      seg_count,
  input  logic [MAX_SEGS*8-1:0] seg_list,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [ADDR_W-1:0]     req_addr,
  input  logic                  rsp_valid,
  output logic                  rsp_ready,
  input  logic [15:0]           rsp_data,
  output logic                  seg_valid,
  output logic                  seg_pass,
  output logic [7:0]            seg_flag,
  output logic [7:0]            seg_id,
  output logic                  busy,
  output logic                  done,
  output logic                  error,
  output logic [7:0]            fail_seg,
  output logic [15:0]           fail_residue
);
  logic                    go;
  logic [ADDR_W-1:0]       base;
  romchk_pkg::seg_result_t res;
  logic [15:0]             res_residue;

  romchk_reader #(.SEG_WORDS(SEG_WORDS), .ADDR_W(ADDR_W), .POLY(POLY)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(go), .base(base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .res_valid(seg_valid), .res(res), .res_residue(res_residue)
  );

  romchk_seq #(.SEG_WORDS(SEG_WORDS), .MAX_SEGS(MAX_SEGS), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_count(seg_count),
    .seg_list(seg_list), .res_valid(seg_valid), .res_pass(res.pass),
    .res_residue(res_residue), .go(go), .base(base), .busy(busy),
    .done(done), .error(error), .fail_seg(fail_seg), .fail_residue(fail_residue)
  );

  assign seg_pass = res.pass;
  assign seg_flag = res.flag;
  assign seg_id   = res.id;
endmodule

// File: rtl/rom_selftest_chk.sv
module rom_selftest_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              seg_valid,
  input logic              seg_pass,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [7:0]        fail_seg,
  input logic [15:0]       fail_residue
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R11
  AST_SEG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |=> !seg_valid); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !$past(start) |-> $past(seg_valid && seg_pass)); // R8
  AST_ERR_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(seg_valid && !seg_pass)); // R7
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R7
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error && $stable(fail_seg) && $stable(fail_residue)); // R7
endmodule

bind rom_selftest rom_selftest_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_rom_selftest.sv
module sim_rom_selftest;
  localparam int SW = 3072;
  localparam int MS = 16;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, req_valid, req_ready, rsp_valid, rsp_ready;
  logic [4:0] seg_count;
  logic [MS*8-1:0] seg_list;
  logic [15:0] req_addr, rsp_data, fail_residue;
  logic seg_valid, seg_pass, busy, done, error;
  logic [7:0] seg_flag, seg_id, fail_seg;

  rom_selftest u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit wd = 0;

  typedef struct {bit pass; bit [7:0] id; bit [7:0] flag; bit [15:0] res; bit last; bit [7:0] lid;} exp_t;
  int   exp_addr[$];
  exp_t exp_res[$];
  int   pipe[$];
  bit   start_req = 0;
  int   bp = 0;
  int   bad_addr = -1;
  logic [15:0] fill [16];
  bit   pend_done = 0, pend_fail = 0, pend_clear = 0, model_err = 0;
  bit [7:0]  pf_seg;
  bit [15:0] pf_res;

  function automatic bit [15:0] crc_step(bit [15:0] c, bit [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      if (c[15] ^ w[i]) c = (c << 1) ^ 16'h1021; else c = c << 1;
    end
    return c;
  endfunction

  function automatic bit [15:0] rom_word(int a);
    int s, o;
    bit [15:0] d;
    s = a / SW; o = a % SW;
    if (o == SW - 2) d = {((s == 6 || s == 7) ? 8'h01 : (s == 15 ? 8'h02 : 8'h00)), 8'(8'h10 + s)};
    else if (o == SW - 1) d = fill[s];
    else d = 16'((a * 40503) ^ (a >> 5) ^ 16'h5A3C);
    if (a == bad_addr) d = d ^ 16'h0004;
    return d;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic void build();
    for (int k = 0; k < seg_count; k++) begin
      exp_t e;
      bit [7:0] id;
      bit [15:0] c, tr;
      int b;
      id = seg_list[k*8 +: 8];
      b = int'(id[3:0]) * SW;
      c = 16'hFFFF;
      for (int o = 0; o < SW; o++) begin
        exp_addr.push_back(b + o);
        c = crc_step(c, rom_word(b + o));
      end
      tr = rom_word(b + SW - 2);
      e.pass = (c == 0); e.id = tr[7:0]; e.flag = tr[15:8]; e.res = c;
      e.last = (k == seg_count - 1); e.lid = id;
      exp_res.push_back(e);
      if (!e.pass) break;
    end
  endfunction

  // Reference model and memory, evaluated on every falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (done || pend_done) chk(done == pend_done, "R8", "done", done, pend_done);
      pend_done = 0;
      if (pend_clear) model_err = 0;
      pend_clear = 0;
      if (pend_fail) begin
        model_err = 1;
        chk(fail_seg == pf_seg, "R7", "fail_seg", fail_seg, pf_seg);
        chk(fail_residue == pf_res, "R7", "fail_residue", fail_residue, pf_res);
      end
      pend_fail = 0;
      if (error != model_err) chk(0, "R7", "error", error, model_err);
      if (seg_valid) begin
        if (exp_res.size() == 0) chk(0, "R6", "unexpected seg_valid", 1, 0);
        else begin
          exp_t e;
          e = exp_res.pop_front();
          chk(seg_pass == e.pass, "R3", "seg_pass", seg_pass, e.pass);
          chk(seg_id == e.id, "R4", "seg_id", seg_id, e.id);
          chk(seg_flag == e.flag, "R4", "seg_flag", seg_flag, e.flag);
          if (!e.pass) begin pend_fail = 1; pf_seg = e.lid; pf_res = e.res; end
          else if (e.last) pend_done = 1;
        end
      end
      start = 0;
      if (start_req) begin
        start = 1; start_req = 0;
        if (!busy) begin
          pend_clear = 1;
          build();
          if (seg_count == 0) pend_done = 1;
        end
      end
      if (pipe.size() > 0 && (bp == 0 || $urandom_range(3) != 0)) begin
        rsp_valid = 1; rsp_data = rom_word(pipe.pop_front());
      end else begin
        rsp_valid = 0; rsp_data = 16'h0;
      end
      req_ready = (bp == 0) ? 1'b1 : ($urandom_range(2) != 0);
      if (req_valid && req_ready) begin
        if (exp_addr.size() == 0) chk(0, "R7", "request after stop", req_addr, 0);
        else begin
          int ea;
          ea = exp_addr.pop_front();
          if (req_addr != 16'(ea)) chk(0, "R2", "req_addr", req_addr, ea);
          else checks++;
        end
        pipe.push_back(int'(req_addr));
      end
    end
  end

  task automatic set_list(int n, int a0, int a1, int a2, int a3, int a4, int a5, int a6, int a7, int a8);
    int v[9];
    v = '{a0, a1, a2, a3, a4, a5, a6, a7, a8};
    @(posedge clk); #1;
    seg_list = '0;
    seg_count = 5'(n);
    for (int i = 0; i < 9; i++) seg_list[i*8 +: 8] = 8'(v[i]);
  endtask

  task automatic run();
    if (!wd) begin
      @(posedge clk); #1; start_req = 1;
      repeat (4) @(posedge clk);
      while (busy && !wd) begin
        @(posedge clk);
        if (cyc > LIMIT) begin
          wd = 1; errors++;
          $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
        end
      end
      repeat (3) @(posedge clk);
      chk(exp_addr.size() == 0, "R6", "addresses left", exp_addr.size(), 0);
      chk(exp_res.size() == 0, "R6", "results left", exp_res.size(), 0);
      chk(busy == 0, "R6", "busy after run", busy, 0);
    end
  endtask

  initial begin
    rst_n = 0; start = 0; req_ready = 0; rsp_valid = 0; rsp_data = 0;
    seg_count = 0; seg_list = '0;
    for (int s = 0; s < 16; s++) begin
      bit [15:0] c;
      fill[s] = 16'h0;
      c = 16'hFFFF;
      for (int o = 0; o < SW - 1; o++) c = crc_step(c, rom_word(s * SW + o));
      fill[s] = c;
    end
    repeat (4) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && error == 0, "R1", "status after reset", {busy, done, error}, 0);
    chk(req_valid == 0 && seg_valid == 0, "R1", "strobes after reset", {req_valid, seg_valid}, 0);
    // R6 R2 R3 R4 R8: start-up order, full rate
    bp = 0;
    set_list(9, 8'h18, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17);
    run();
    // R11: stalls on both channels, high slot
    bp = 1;
    set_list(3, 8'h2F, 8'h16, 8'h13, 0, 0, 0, 0, 0, 0);
    run();
    // R9: start while busy is ignored
    bp = 0;
    set_list(2, 8'h11, 8'h14, 0, 0, 0, 0, 0, 0, 0);
    if (!wd) begin
      @(posedge clk); #1; start_req = 1;
      repeat (1000) @(posedge clk); #1;
      chk(busy == 1, "R9", "busy mid-run", busy, 1);
      start_req = 1;
      repeat (4) @(posedge clk);
      while (busy && cyc < LIMIT) @(posedge clk);
      repeat (3) @(posedge clk);
      chk(exp_addr.size() == 0 && exp_res.size() == 0, "R9", "stream after ignored start", exp_addr.size(), 0);
    end
    // R7: corrupted word in the second segment stops the list
    bad_addr = 1 * SW + 777;
    set_list(3, 8'h18, 8'h11, 8'h12, 0, 0, 0, 0, 0, 0);
    run();
    chk(error == 1, "R7", "error held", error, 1);
    // R10 R9: empty list pulses done and clears error
    set_list(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run();
    chk(error == 0, "R9", "error cleared", error, 0);
    // R3: corrupted filler word with stalls
    bp = 1;
    bad_addr = 3 * SW + SW - 1;
    set_list(1, 8'h13, 0, 0, 0, 0, 0, 0, 0, 0);
    run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule